// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Per-Byte and Block Error Reporting

This block turns an asynchronous serial line into bytes. It keeps the bytes in a small receive queue until the host reads them. A 16x oversampling enable, driven from an external baud source, sets the bit timing. Each frame has a start bit, eight data bits sent LSB first, one parity bit and one stop bit. The block stores every received byte together with three flags: break, framing error and parity error.

The host reads a four-bit error status. This status works in one of two modes. In the default per-byte mode, each read loads the status with the flags of the byte just removed from the queue. In block mode, the flags of every byte are merged into the status as the byte enters the queue, and reads leave the status alone. This lets software check a whole burst once at the end.

A three-bit command input controls the receiver. There are commands to enable and disable it, to reset it, to clear the error status and to enter block mode. Disabling stops reception and leaves the stored bytes and status as they are. Resetting also throws away everything stored.

Top module: `uart_rx_channel`

## Requirements
- R1: A frame is a low start bit, eight data bits LSB first, an even parity bit (the XOR of the data) and a high stop bit. With the default parity setting, a correct frame delivers its data byte unchanged to `rd_data` with no flags.
- R2: A start is accepted only after the line has been seen high and then falls. The line must still be low at the 8th of 16 sub-samples. A low pulse shorter than that produces no byte.
- R3: Per-byte mode is the mode after reset. In this mode, a read of a byte replaces `err_status[3:1]` with that byte's flags: bit 3 break, bit 2 framing error (stop bit low), bit 1 parity error.
- R4: Command 5 selects block mode. In block mode, the flags of each stored byte are ORed into `err_status[3:1]` when the byte enters the queue, and reads do not change the status.
- R5: Command 4 clears all four `err_status` bits and has priority over any same-cycle update. It does not leave block mode.
- R6: The queue holds 8 entries. A byte that completes while the queue is full is discarded and sets `err_status[0]` (overrun). The overrun bit stays set until command 4, command 3 or `rst`.
- R7: A frame whose data, parity and stop bits are all low is a break. It stores one entry with data 0x00 and only the break flag. No further byte is stored until the line has returned high.
- R8: Command 2 disables the receiver at once and drops any frame in progress. Stored bytes stay readable and `err_status` does not change.
- R9: Command 3 disables the receiver, empties the queue, clears `err_status` and returns to per-byte mode.
- R10: After `rst`, the receiver is disabled, the queue is empty, the status is zero and per-byte mode is selected.
- R11: Command 1 enables reception. While the receiver is disabled, frames on the line store nothing. Codes 0, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cmd_code | input | 3 | Command, valid for one cycle (0 none, 1 enable, 2 disable, 3 reset receiver, 4 clear errors, 5 block mode) |
| rd_en | input | 1 | Removes the head byte from the queue when one is available |
| rd_data | output | 8 | Data of the head entry |
| rd_avail | output | 1 | Queue is not empty |
| err_status | output | 4 | {break, framing, parity, overrun} |
| rx_enabled | output | 1 | Receiver is enabled |

## Verification
The checker watches the command effects on every cycle:
- Clearing and resetting zero the status on the next cycle.
- A disable leaves both the status and data availability untouched.
- Overrun sets when a byte arrives with the queue full, and then stays set.
- In block mode, reads never change the status.
- While the receiver is disabled, nothing is stored.

Only the bench scenarios can show what depends on serial timing and byte contents:
- the recovered byte values and their order;
- rejection of short start glitches;
- break handling;
- which flags a given bad frame produces;
- block accumulation across several frames.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;

    localparam logic [2:0] CMD_NONE    = 3'd0;
    localparam logic [2:0] CMD_ENABLE  = 3'd1;
    localparam logic [2:0] CMD_DISABLE = 3'd2;
    localparam logic [2:0] CMD_RESET   = 3'd3;
    localparam logic [2:0] CMD_CLR_ERR = 3'd4;
    localparam logic [2:0] CMD_BLOCK   = 3'd5;

    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } rx_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        rx_flags_t         flags;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    function automatic logic expected_parity(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit ODD_PARITY  = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      tick,
    input  logic      rxd,
    output logic      frm_push,
    output rx_entry_t frm_entry
);
    localparam int SUBS = 16;
    localparam logic [3:0] MID_START = 4'(SUBS / 2 - 1);
    localparam logic [3:0] LAST_SUB  = 4'(SUBS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    rx_state_e              state;
    logic [3:0]             sub_cnt;
    logic [2:0]             bit_idx;
    logic [DATA_W-1:0]      shreg;
    logic                   par_q;
    logic                   armed;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
    assign rx_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state     <= ST_IDLE;
            sub_cnt   <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_q     <= 1'b0;
            armed     <= 1'b0;
            frm_push  <= 1'b0;
            frm_entry <= '0;
        end else begin
            frm_push <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rx_s && armed) begin
                            state   <= ST_START;
                            sub_cnt <= 4'd1;
                            armed   <= 1'b0;
                        end else if (rx_s) begin
                            armed <= 1'b1;
                        end
                    end
                    ST_START: begin
                        if (sub_cnt == MID_START) begin
                            sub_cnt <= '0;
                            bit_idx <= '0;
                            state   <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            sub_cnt <= sub_cnt + 4'd1;
                        end
                    end
                    ST_DATA: begin
                        if (sub_cnt == LAST_SUB) begin
                            sub_cnt <= '0;
                            shreg   <= {rx_s, shreg[DATA_W-1:1]};
                            if (bit_idx == 3'(DATA_W - 1)) state <= ST_PAR;
                            else bit_idx <= bit_idx + 3'd1;
                        end else begin
                            sub_cnt <= sub_cnt + 4'd1;
                        end
                    end
                    ST_PAR: begin
                        if (sub_cnt == LAST_SUB) begin
                            sub_cnt <= '0;
                            par_q   <= rx_s;
                            state   <= ST_STOP;
                        end else begin
                            sub_cnt <= sub_cnt + 4'd1;
                        end
                    end
                    ST_STOP: begin
                        if (sub_cnt == LAST_SUB) begin
                            sub_cnt  <= '0;
                            state    <= ST_IDLE;
                            frm_push <= 1'b1;
                            if (!rx_s && shreg == '0 && !par_q) begin
                                frm_entry.data  <= '0;
                                frm_entry.flags <= '{brk: 1'b1, fe: 1'b0, pe: 1'b0};
                            end else begin
                                frm_entry.data  <= shreg;
                                frm_entry.flags <= '{brk: 1'b0, fe: !rx_s,
                                    pe: (par_q != expected_parity(shreg, ODD_PARITY))};
                            end
                        end else begin
                            sub_cnt <= sub_cnt + 4'd1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      push,
    input  rx_entry_t wr_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [AW:0]     level;
    logic            do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !clear) mem[wp] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/uart_rx_errstat.sv
module uart_rx_errstat
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_reset,
    input  logic      clr_err,
    input  logic      set_block,
    input  logic      stored,
    input  rx_flags_t stored_flags,
    input  logic      overflow,
    input  logic      popped,
    input  rx_flags_t popped_flags,
    output logic [3:0] status,
    output logic      block_mode
);
    always_ff @(posedge clk) begin
        if (rst || rx_reset) begin
            status     <= '0;
            block_mode <= 1'b0;
        end else begin
            if (set_block) block_mode <= 1'b1;
            if (clr_err) begin
                status <= '0;
            end else begin
                if (overflow) status[0] <= 1'b1;
                if (block_mode) begin
                    if (stored) status[3:1] <= status[3:1] | stored_flags;
                end else if (popped) begin
                    status[3:1] <= popped_flags;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_channel.sv
module uart_rx_channel
    import uart_rx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit ODD_PARITY  = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [2:0] cmd_code,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_avail,
    output logic [3:0] err_status,
    output logic       rx_enabled
);
    logic      en_q, kill, run;
    logic      frm_push, push_ok, stored, overflow, pop_ok;
    logic      fifo_empty, fifo_full, block_mode;
    rx_entry_t frm_entry, head;

    assign kill = (cmd_code == CMD_DISABLE) || (cmd_code == CMD_RESET);
    assign run  = en_q && !kill;

    always_ff @(posedge clk) begin
        if (rst || kill)                  en_q <= 1'b0;
        else if (cmd_code == CMD_ENABLE)  en_q <= 1'b1;
    end

    uart_rx_deser #(.SYNC_STAGES(SYNC_STAGES), .ODD_PARITY(ODD_PARITY)) u_deser (
        .clk(clk), .rst(rst), .run(run), .tick(tick16), .rxd(rxd),
        .frm_push(frm_push), .frm_entry(frm_entry)
    );

    assign push_ok  = frm_push && run;
    assign stored   = push_ok && !fifo_full;
    assign overflow = push_ok && fifo_full;
    assign pop_ok   = rd_en && !fifo_empty;

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .clear(cmd_code == CMD_RESET),
        .push(push_ok), .wr_entry(frm_entry), .pop(rd_en),
        .head(head), .empty(fifo_empty), .full(fifo_full)
    );

    uart_rx_errstat u_err (
        .clk(clk), .rst(rst),
        .rx_reset(cmd_code == CMD_RESET),
        .clr_err(cmd_code == CMD_CLR_ERR),
        .set_block(cmd_code == CMD_BLOCK),
        .stored(stored), .stored_flags(frm_entry.flags),
        .overflow(overflow),
        .popped(pop_ok), .popped_flags(head.flags),
        .status(err_status), .block_mode(block_mode)
    );

    assign rd_data    = head.data;
    assign rd_avail   = !fifo_empty;
    assign rx_enabled = en_q;
endmodule

// File: rtl/uart_rx_channel_chk.sv
module uart_rx_channel_chk
    import uart_rx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] cmd_code,
    input logic       rd_en,
    input logic       rd_avail,
    input logic [3:0] err_status,
    input logic       rx_enabled,
    input logic       push_ok,
    input logic       fifo_full,
    input logic       block_mode
);
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (!rx_enabled && !rd_avail && err_status == 4'd0 && !block_mode));

    a_r9_rx_reset: assert property (@(posedge clk) disable iff (rst)
        cmd_code == CMD_RESET |=> (!rx_enabled && !rd_avail && err_status == 4'd0));

    a_r5_clear_err: assert property (@(posedge clk) disable iff (rst)
        cmd_code == CMD_CLR_ERR |=> err_status == 4'd0);

    a_r8_disable_keeps: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_DISABLE && !rd_en) |=> ($stable(err_status) && $stable(rd_avail)));

    a_r11_idle_disabled: assert property (@(posedge clk) disable iff (rst)
        (!rx_enabled && !rd_en && cmd_code == CMD_NONE) |=> ($stable(err_status) && $stable(rd_avail)));

    a_r4_block_read_quiet: assert property (@(posedge clk) disable iff (rst)
        (block_mode && rd_en && !push_ok && cmd_code == CMD_NONE) |=> $stable(err_status));

    a_r6_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && push_ok && cmd_code == CMD_NONE) |=> err_status[0]);

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_status[0] && cmd_code != CMD_CLR_ERR && cmd_code != CMD_RESET) |=> err_status[0]);
endmodule

bind uart_rx_channel uart_rx_channel_chk u_chk (
    .clk(clk), .rst(rst), .cmd_code(cmd_code), .rd_en(rd_en),
    .rd_avail(rd_avail), .err_status(err_status), .rx_enabled(rx_enabled),
    .push_ok(push_ok), .fifo_full(fifo_full), .block_mode(block_mode)
);

// File: tb/uart_rx_channel_bench.sv
module uart_rx_channel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int BIT_CYC    = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] cmd_code = 3'd0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_avail;
    logic [3:0] err_status;
    logic       rx_enabled;

    int checks = 0;
    int failures = 0;
    logic [10:0] exp_q[$];
    int tick_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        tick16   <= (tick_cnt == TICK_DIV - 1);
    end

    uart_rx_channel u_uart_rx_channel (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .cmd_code(cmd_code),
        .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail),
        .err_status(err_status), .rx_enabled(rx_enabled)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c);
        @(negedge clk);
        cmd_code = c;
        @(negedge clk);
        cmd_code = 3'd0;
        repeat (2) @(negedge clk);
    endtask

    task automatic hold(input logic b, input int nbits);
        rxd = b;
        repeat (nbits * BIT_CYC) @(negedge clk);
    endtask

    // driver: shifts one frame out and records what the receiver should store
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                              input bit expect_store);
        hold(1'b0, 1);
        for (int i = 0; i < 8; i++) hold(d[i], 1);
        hold((^d) ^ bad_par, 1);
        hold(!bad_stop, 1);
        hold(1'b1, 2);
        if (expect_store) exp_q.push_back({d, 1'b0, bad_stop, bad_par});
    endtask

    // monitor: pops the next expected entry and compares with what the design shows
    task automatic read_check(input string req, input bit check_status);
        logic [10:0] e;
        @(negedge clk);
        if (exp_q.size() == 0) begin
            chk(1'b0, req, 0, 1);
            return;
        end
        e = exp_q.pop_front();
        chk(rd_avail == 1'b1, req, int'(rd_avail), 1);
        chk(rd_data == e[10:3], req, int'(rd_data), int'(e[10:3]));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (check_status)
            chk(err_status[3:1] == e[2:0], req, int'(err_status[3:1]), int'(e[2:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [3:0] st;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rx_enabled && !rd_avail && err_status == 4'd0, "R10 reset state",
            int'({rx_enabled, rd_avail, err_status}), 0);

        // R11: disabled receiver and unused codes store nothing
        issue(3'd6);
        send_frame(8'h5E, 1'b0, 1'b0, 1'b0);
        chk(!rd_avail && !rx_enabled, "R11 disabled stores nothing", int'(rd_avail), 0);

        issue(3'd1);
        chk(rx_enabled, "R11 enable", int'(rx_enabled), 1);

        // R1 normal frames
        send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        send_frame(8'hFF, 1'b0, 1'b0, 1'b1);
        read_check("R1 data A5", 1'b1);
        read_check("R1 data 3C", 1'b1);
        read_check("R1 data FF", 1'b1);

        // R3 per-byte flags replaced on each read
        send_frame(8'h96, 1'b1, 1'b0, 1'b1);
        send_frame(8'h55, 1'b0, 1'b1, 1'b1);
        send_frame(8'h01, 1'b0, 1'b0, 1'b1);
        chk(err_status == 4'd0, "R3 no status before read", int'(err_status), 0);
        read_check("R3 parity flag", 1'b1);
        read_check("R3 framing flag", 1'b1);
        read_check("R3 flags replaced", 1'b1);

        // R2 short start glitch
        rxd = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        hold(1'b1, 3);
        chk(!rd_avail, "R2 glitch rejected", int'(rd_avail), 0);

        // R7 break
        hold(1'b0, 14);
        hold(1'b1, 2);
        exp_q.push_back({8'h00, 3'b100});
        read_check("R7 break entry", 1'b1);
        chk(!rd_avail, "R7 single break entry", int'(rd_avail), 0);

        // R5 clear
        issue(3'd4);
        chk(err_status == 4'd0, "R5 clear status", int'(err_status), 0);

        // R6 overrun
        for (int i = 0; i < 9; i++) send_frame(8'(8'h10 + i), 1'b0, 1'b0, i < 8);
        chk(err_status[0] == 1'b1, "R6 overrun set", int'(err_status), 1);
        for (int i = 0; i < 8; i++) read_check("R6 kept order", 1'b0);
        chk(!rd_avail, "R6 ninth discarded", int'(rd_avail), 0);
        chk(err_status[0] == 1'b1, "R6 overrun sticky", int'(err_status), 1);
        issue(3'd4);
        chk(err_status == 4'd0, "R5 clear overrun", int'(err_status), 0);

        // R8 disable mid-frame
        send_frame(8'h11, 1'b1, 1'b0, 1'b1);
        st = err_status;
        hold(1'b0, 1);
        for (int i = 0; i < 3; i++) hold(1'b1, 1);
        @(negedge clk);
        cmd_code = 3'd2;
        @(negedge clk);
        cmd_code = 3'd0;
        for (int i = 0; i < 6; i++) hold(1'b0, 1);
        hold(1'b1, 3);
        chk(!rx_enabled, "R8 disabled", int'(rx_enabled), 0);
        chk(err_status == st, "R8 status unchanged", int'(err_status), int'(st));
        read_check("R8 stored byte kept", 1'b1);
        chk(!rd_avail, "R8 partial frame dropped", int'(rd_avail), 0);

        // R4 block mode
        issue(3'd1);
        issue(3'd4);
        issue(3'd5);
        send_frame(8'h5A, 1'b1, 1'b0, 1'b1);
        chk(err_status == 4'b0010, "R4 flag at store", int'(err_status), 2);
        send_frame(8'h21, 1'b0, 1'b0, 1'b1);
        chk(err_status == 4'b0010, "R4 accumulated", int'(err_status), 2);
        read_check("R4 data", 1'b0);
        read_check("R4 data", 1'b0);
        chk(err_status == 4'b0010, "R4 reads keep status", int'(err_status), 2);
        issue(3'd4);
        chk(err_status == 4'd0, "R5 clear in block", int'(err_status), 0);
        send_frame(8'h33, 1'b0, 1'b1, 1'b1);
        chk(err_status == 4'b0100, "R5 block mode kept", int'(err_status), 4);
        read_check("R4 data", 1'b0);

        // R9 reset receiver
        send_frame(8'h44, 1'b0, 1'b0, 1'b0);
        issue(3'd3);
        chk(!rd_avail && !rx_enabled && err_status == 4'd0, "R9 reset receiver",
            int'({rd_avail, rx_enabled, err_status}), 0);
        issue(3'd1);
        send_frame(8'h66, 1'b1, 1'b0, 1'b1);
        chk(err_status == 4'd0, "R9 per-byte mode back", int'(err_status), 0);
        read_check("R9 per-byte flag on read", 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule